// File: doc/BRIEF.md
# Channel Data Buffer with Command Hold-off

This block sits on one disk-style channel between the host side and the device side. Every host access to the data port goes through a byte-counted buffer. In post mode the host writes and the device drains. In prefetch mode the device fills and the host reads. Both modes use the buffer, and no other path exists for data-port traffic.

Host accesses to the command or control registers skip the buffer and go straight to a side strobe. They are still ordered against data already in flight. In post mode such an access waits until the buffer is empty. In prefetch mode it waits until the buffer is full. While it waits, the host is held with its ready signal low; the access is never rejected.

The host side moves 16-bit words or 32-bit double-words. The device side moves 16-bit words with strobe/ready handshakes. The depth is 64 bytes, or 32 bytes when the depth select input is set.

Top module: `chan_databuf`

## Requirements
- R1: After reset the buffer is empty, the mode is post, the depth is 64 bytes, and d_wrdy, d_rvld, cc_stb and h_rdy are all low while no request is present.
- R2: In post mode a host data write (h_ctl=0, h_wr=1) is acknowledged in the same cycle exactly when the free space is at least its size: 4 bytes when h_dword=1, 2 bytes when h_dword=0. An accepted write adds that many bytes to the level.
- R3: In post mode d_rvld is high exactly when at least 2 bytes are held. d_rdata presents the oldest word. Double-words are stored low half (h_wdata[15:0]) first, and d_rstb while d_rvld is high removes one word.
- R4: In prefetch mode d_wrdy is high exactly when at least 2 bytes are free, and d_wstb while d_wrdy is high stores d_wdata. A host data read is acknowledged exactly when the level is at least its size. h_rdata[15:0] then holds the oldest word, and h_rdata[31:16] holds the next word for a double-word read or zero for a word read.
- R5: A host data access whose direction is opposite to the mode (a read in post mode, a write in prefetch mode) is never acknowledged and leaves the buffer unchanged.
- R6: In post mode a command/control access (h_ctl=1) is held with h_rdy low until the buffer is empty, and is then acknowledged.
- R7: In prefetch mode a command/control access is held until the level equals the selected depth, and is then acknowledged.
- R8: An acknowledged command/control access pulses cc_stb in that cycle and drives cc_wr=h_wr and cc_wdata=h_wdata[15:0]. A read returns {16'b0, cc_rdata} on h_rdata. The buffer is not changed.
- R9: cfg_prefetch and cfg_half_depth (1 selects 32 bytes) are taken in only at an edge where the buffer is empty and nothing enters it. At any other edge the active mode and depth are kept.
- R10: A push and a pop in the same cycle both take effect, and the level changes by the bytes pushed minus the bytes popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_prefetch | input | 1 | Mode select: 1 prefetch, 0 post |
| cfg_half_depth | input | 1 | Depth select: 1 for 32 bytes, 0 for 64 bytes |
| h_req | input | 1 | Host access request |
| h_ctl | input | 1 | Address class: 1 command/control, 0 data port |
| h_wr | input | 1 | Host direction: 1 write |
| h_dword | input | 1 | Host size: 1 double-word, 0 word |
| h_wdata | input | 32 | Host write data |
| h_rdy | output | 1 | Access completes this cycle |
| h_rdata | output | 32 | Host read data |
| d_wstb | input | 1 | Device word write strobe (prefetch fill) |
| d_wdata | input | 16 | Device word write data |
| d_wrdy | output | 1 | Buffer can take a device word |
| d_rstb | input | 1 | Device word read strobe (post drain) |
| d_rdata | output | 16 | Oldest buffered word |
| d_rvld | output | 1 | A word is available to the device |
| cc_stb | output | 1 | Command/control access strobe |
| cc_wr | output | 1 | Command/control direction |
| cc_wdata | output | 16 | Command/control write data |
| cc_rdata | input | 16 | Command/control read data |

## Verification
Two things can fall in the same cycle: a host push and a device pop, or a device push and a host pop. The bench provokes both by keeping a strobe on the device side while it issues host data accesses of mixed size across the whole level range, right up to full and empty. Each cycle it compares every handshake and data output against a byte-counted queue model. That model applies pops before pushes and the configuration rule only on empty cycles with no push. Held command/control requests are kept up across these sweeps, and the cycle in which they are granted is checked against the model's empty or full condition.

// File: rtl/cdb_pkg.sv
package cdb_pkg;
  localparam int HW = 16;
  localparam int DW = 2 * HW;

  typedef enum logic {
    DIR_POST = 1'b0,
    DIR_PREF = 1'b1
  } dir_e;

  // bytes carried by one host transfer
  function automatic logic [2:0] xfer_bytes(input logic dword);
    return dword ? 3'd4 : 3'd2;
  endfunction

  // word slots carried by one host transfer
  function automatic logic [1:0] xfer_slots(input logic dword);
    return dword ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/cdb_rst_sync.sv
module cdb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/cdb_cfg.sv
module cdb_cfg
  import cdb_pkg::*;
#(
  parameter int DEPTH_BYTES = 64,
  parameter int HALF_BYTES  = 32,
  localparam int LW = $clog2(DEPTH_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          empty,
  input  logic          push_any,
  input  logic          cfg_prefetch,
  input  logic          cfg_half_depth,
  output dir_e          dir_q,
  output logic [LW-1:0] cap_q
);
  logic          cfg_en;
  dir_e          dir_d;
  logic [LW-1:0] cap_d;

  // new settings only land on an idle, empty buffer
  assign cfg_en = empty & ~push_any;

  always_comb begin
    dir_d = dir_q;
    cap_d = cap_q;
    if (cfg_en) begin
      dir_d = cfg_prefetch ? DIR_PREF : DIR_POST;
      cap_d = cfg_half_depth ? LW'(HALF_BYTES) : LW'(DEPTH_BYTES);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= DIR_POST;
      cap_q <= LW'(DEPTH_BYTES);
    end else begin
      dir_q <= dir_d;
      cap_q <= cap_d;
    end
  end

  assert_cfg_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |=> ($stable(cap_q) && $stable(dir_q)));
endmodule

// File: rtl/cdb_store.sv
module cdb_store
  import cdb_pkg::*;
#(
  parameter int DEPTH_BYTES = 64,
  localparam int SLOTS = DEPTH_BYTES / 2,
  localparam int PW    = $clog2(SLOTS),
  localparam int LW    = $clog2(DEPTH_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    push_n,
  input  logic [HW-1:0] push_lo,
  input  logic [HW-1:0] push_hi,
  input  logic [1:0]    pop_n,
  output logic [HW-1:0] head0,
  output logic [HW-1:0] head1,
  output logic [LW-1:0] lvl
);
  logic [HW-1:0] mem [SLOTS];
  logic [PW-1:0] wp_q, wp_d, wp_p1;
  logic [PW-1:0] rp_q, rp_d, rp_p1;
  logic [LW-1:0] lvl_q, lvl_d;
  logic [LW-1:0] in_b, out_b;

  assign in_b  = LW'({push_n, 1'b0});
  assign out_b = LW'({pop_n, 1'b0});
  assign wp_p1 = wp_q + PW'(1);
  assign rp_p1 = rp_q + PW'(1);

  always_comb begin
    wp_d  = wp_q + PW'(push_n);
    rp_d  = rp_q + PW'(pop_n);
    lvl_d = lvl_q + in_b - out_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      lvl_q <= lvl_d;
    end
  end

  // storage array, no reset
  always_ff @(posedge clk) begin
    if (push_n != 2'd0) mem[wp_q]  <= push_lo;
    if (push_n == 2'd2) mem[wp_p1] <= push_hi;
  end

  assign head0 = mem[rp_q];
  assign head1 = mem[rp_p1];
  assign lvl   = lvl_q;

  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_b <= lvl_q);
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_q + in_b) <= LW'(DEPTH_BYTES));
endmodule

// File: rtl/cdb_gate.sv
module cdb_gate
  import cdb_pkg::*;
#(
  parameter int DEPTH_BYTES = 64,
  localparam int LW = $clog2(DEPTH_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dir_e          dir,
  input  logic [LW-1:0] cap,
  input  logic [LW-1:0] lvl,
  input  logic          h_req,
  input  logic          h_ctl,
  input  logic          h_wr,
  input  logic          h_dword,
  input  logic          d_wstb,
  input  logic          d_rstb,
  output logic          h_rdy,
  output logic          cc_stb,
  output logic          d_wrdy,
  output logic          d_rvld,
  output logic [1:0]    push_n,
  output logic [1:0]    pop_n,
  output logic          push_from_dev
);
  logic          pref;
  logic [LW-1:0] free_b;
  logic [LW-1:0] need_b;
  logic          dir_match;
  logic          data_ok;
  logic          ctl_ok;
  logic          dev_push;
  logic          dev_pop;

  assign pref      = (dir == DIR_PREF);
  assign free_b    = cap - lvl;
  assign need_b    = LW'(xfer_bytes(h_dword));
  assign dir_match = (h_wr != pref);

  always_comb begin
    data_ok = 1'b0;
    if (h_req && !h_ctl && dir_match)
      data_ok = h_wr ? (free_b >= need_b) : (lvl >= need_b);
  end

  // bypass access waits for drain (post) or fill (prefetch)
  assign ctl_ok = h_req & h_ctl & (pref ? (lvl == cap) : (lvl == '0));

  assign h_rdy  = data_ok | ctl_ok;
  assign cc_stb = ctl_ok;

  assign d_wrdy   = pref & (free_b >= LW'(2));
  assign d_rvld   = ~pref & (lvl >= LW'(2));
  assign dev_push = d_wstb & d_wrdy;
  assign dev_pop  = d_rstb & d_rvld;

  always_comb begin
    push_n = 2'd0;
    pop_n  = 2'd0;
    if (pref) begin
      push_n = {1'b0, dev_push};
      if (data_ok) pop_n = xfer_slots(h_dword);
    end else begin
      pop_n = {1'b0, dev_pop};
      if (data_ok) push_n = xfer_slots(h_dword);
    end
  end

  assign push_from_dev = pref;

  assert_dir_mismatch_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (h_req && !h_ctl && (h_wr == pref)) |-> !h_rdy);
  assert_ctl_post_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_stb && !pref) |-> (lvl == '0));
  assert_ctl_pref_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_stb && pref) |-> (lvl == cap));
  assert_level_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    lvl <= cap);
  assert_ctl_no_move_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cc_stb |-> (push_n == 2'd0 || pref) && (pop_n == 2'd0 || !pref));
endmodule

// File: rtl/chan_databuf.sv
module chan_databuf
  import cdb_pkg::*;
#(
  parameter int DEPTH_BYTES = 64,
  parameter int HALF_BYTES  = 32,
  localparam int LW = $clog2(DEPTH_BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_prefetch,
  input  logic          cfg_half_depth,
  input  logic          h_req,
  input  logic          h_ctl,
  input  logic          h_wr,
  input  logic          h_dword,
  input  logic [31:0]   h_wdata,
  output logic          h_rdy,
  output logic [31:0]   h_rdata,
  input  logic          d_wstb,
  input  logic [15:0]   d_wdata,
  output logic          d_wrdy,
  input  logic          d_rstb,
  output logic [15:0]   d_rdata,
  output logic          d_rvld,
  output logic          cc_stb,
  output logic          cc_wr,
  output logic [15:0]   cc_wdata,
  input  logic [15:0]   cc_rdata
);
  logic          rst_i_n;
  dir_e          dir_q;
  logic [LW-1:0] cap_q;
  logic [LW-1:0] lvl;
  logic [1:0]    push_n;
  logic [1:0]    pop_n;
  logic          push_from_dev;
  logic [HW-1:0] push_lo, push_hi;
  logic [HW-1:0] head0, head1;

  cdb_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  cdb_cfg #(.DEPTH_BYTES(DEPTH_BYTES), .HALF_BYTES(HALF_BYTES)) u_cfg (
    .clk            (clk),
    .rst_n          (rst_i_n),
    .empty          (lvl == '0),
    .push_any       (push_n != 2'd0),
    .cfg_prefetch   (cfg_prefetch),
    .cfg_half_depth (cfg_half_depth),
    .dir_q          (dir_q),
    .cap_q          (cap_q)
  );

  cdb_gate #(.DEPTH_BYTES(DEPTH_BYTES)) u_gate (
    .clk           (clk),
    .rst_n         (rst_i_n),
    .dir           (dir_q),
    .cap           (cap_q),
    .lvl           (lvl),
    .h_req         (h_req),
    .h_ctl         (h_ctl),
    .h_wr          (h_wr),
    .h_dword       (h_dword),
    .d_wstb        (d_wstb),
    .d_rstb        (d_rstb),
    .h_rdy         (h_rdy),
    .cc_stb        (cc_stb),
    .d_wrdy        (d_wrdy),
    .d_rvld        (d_rvld),
    .push_n        (push_n),
    .pop_n         (pop_n),
    .push_from_dev (push_from_dev)
  );

  assign push_lo = push_from_dev ? d_wdata : h_wdata[HW-1:0];
  assign push_hi = push_from_dev ? d_wdata : h_wdata[DW-1:HW];

  cdb_store #(.DEPTH_BYTES(DEPTH_BYTES)) u_store (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .push_n  (push_n),
    .push_lo (push_lo),
    .push_hi (push_hi),
    .pop_n   (pop_n),
    .head0   (head0),
    .head1   (head1),
    .lvl     (lvl)
  );

  always_comb begin
    if (h_ctl) h_rdata = {16'h0000, cc_rdata};
    else       h_rdata = {(h_dword ? head1 : 16'h0000), head0};
  end

  assign d_rdata  = head0;
  assign cc_wr    = h_wr;
  assign cc_wdata = h_wdata[15:0];
endmodule

// File: tb/sim_chan_databuf.sv
`timescale 1ns/1ps
module sim_chan_databuf;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_prefetch = 1'b0, cfg_half_depth = 1'b0;
  logic h_req = 1'b0, h_ctl = 1'b0, h_wr = 1'b0, h_dword = 1'b0;
  logic [31:0] h_wdata = '0;
  logic h_rdy;
  logic [31:0] h_rdata;
  logic d_wstb = 1'b0, d_rstb = 1'b0;
  logic [15:0] d_wdata = '0;
  logic d_wrdy, d_rvld, cc_stb, cc_wr;
  logic [15:0] d_rdata, cc_wdata;
  logic [15:0] cc_rdata = 16'h5A3C;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [15:0] q[$];
  bit m_pf = 0;
  int m_cap = 64;

  always #2.5 clk = ~clk;

  chan_databuf u0 (
    .clk(clk), .rst_n(rst_n), .cfg_prefetch(cfg_prefetch), .cfg_half_depth(cfg_half_depth),
    .h_req(h_req), .h_ctl(h_ctl), .h_wr(h_wr), .h_dword(h_dword), .h_wdata(h_wdata),
    .h_rdy(h_rdy), .h_rdata(h_rdata), .d_wstb(d_wstb), .d_wdata(d_wdata), .d_wrdy(d_wrdy),
    .d_rstb(d_rstb), .d_rdata(d_rdata), .d_rvld(d_rvld), .cc_stb(cc_stb), .cc_wr(cc_wr),
    .cc_wdata(cc_wdata), .cc_rdata(cc_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive, compare against model, advance model
  task automatic step(input bit hq, input bit hc, input bit hw, input bit hd,
                      input logic [31:0] hwd, input bit ws, input logic [15:0] wd, input bit rs);
    int lvl, sz, npush;
    bit e_rdy, e_wrdy, e_rvld;
    string rq;
    @(negedge clk);
    h_req = hq; h_ctl = hc; h_wr = hw; h_dword = hd; h_wdata = hwd;
    d_wstb = ws; d_wdata = wd; d_rstb = rs;
    cc_rdata = hwd[31:16] ^ 16'h0F0F;
    #1;
    lvl = q.size() * 2;
    sz = hd ? 4 : 2;
    if (!hq) begin e_rdy = 0; rq = "R1"; end
    else if (hc) begin e_rdy = m_pf ? (lvl == m_cap) : (lvl == 0); rq = m_pf ? "R7" : "R6"; end
    else if (hw == m_pf) begin e_rdy = 0; rq = "R5"; end
    else if (hw) begin e_rdy = (m_cap - lvl) >= sz; rq = "R2"; end
    else begin e_rdy = lvl >= sz; rq = "R4"; end
    e_wrdy = m_pf && (m_cap - lvl) >= 2;
    e_rvld = !m_pf && lvl >= 2;
    chk(h_rdy == e_rdy, rq, 32'(h_rdy), 32'(e_rdy));
    chk(d_wrdy == e_wrdy, "R4 d_wrdy", 32'(d_wrdy), 32'(e_wrdy));
    chk(d_rvld == e_rvld, "R3 d_rvld", 32'(d_rvld), 32'(e_rvld));
    chk(cc_stb == (e_rdy && hc), "R8 cc_stb", 32'(cc_stb), 32'(e_rdy && hc));
    if (e_rvld) chk(d_rdata == q[0], "R3 d_rdata", 32'(d_rdata), 32'(q[0]));
    if (e_rdy && hc) begin
      chk(cc_wr == hw && cc_wdata == hwd[15:0], "R8 cc write",
          {15'd0, cc_wr, cc_wdata}, {15'd0, hw, hwd[15:0]});
      if (!hw) chk(h_rdata == {16'h0, cc_rdata}, "R8 cc read", h_rdata, {16'h0, cc_rdata});
    end
    if (e_rdy && !hc && !hw) begin
      logic [31:0] ex;
      ex = hd ? {q[1], q[0]} : {16'h0, q[0]};
      chk(h_rdata == ex, "R4 h_rdata", h_rdata, ex);
    end
    // advance model: pops, then pushes (R10: both in one cycle)
    npush = 0;
    if (e_rvld && rs) void'(q.pop_front());
    if (e_rdy && !hc && !hw) begin
      void'(q.pop_front());
      if (hd) void'(q.pop_front());
    end
    if (e_wrdy && ws) begin q.push_back(wd); npush = 1; end
    if (e_rdy && !hc && hw) begin
      q.push_back(hwd[15:0]); npush = 1;
      if (hd) q.push_back(hwd[31:16]);
    end
    // R9: configuration lands only on an empty, idle edge
    if (lvl == 0 && npush == 0) begin
      m_pf = cfg_prefetch;
      m_cap = cfg_half_depth ? 32 : 64;
    end
  endtask

  function automatic logic [31:0] pat(input int i);
    return 32'hA5C30000 ^ (32'(i) * 32'h00071013);
  endfunction

  initial begin
    #900000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    chk(!d_wrdy && !d_rvld && !cc_stb && !h_rdy, "R1 reset",
        {28'd0, d_wrdy, d_rvld, cc_stb, h_rdy}, 32'd0);
    step(1, 1, 0, 0, 32'h11112222, 0, 0, 0); // R6 empty post: granted at once

    // R2 fill in post mode with mixed sizes, beyond full
    for (int i = 0; i < 40; i++) step(1, 0, 1, (i % 3) != 0, pat(i), 0, 0, 0);
    for (int i = 0; i < 3; i++) step(1, 1, 1, 0, pat(100 + i), 0, 0, 0); // R6 held
    for (int i = 0; i < 2; i++) step(1, 0, 0, 1, 0, 0, 0, 0);            // R5 read in post
    // R10 concurrent host push and device pop
    for (int i = 0; i < 40; i++) step(1, 0, 1, i[0], pat(200 + i), 0, 0, 1);
    // drain with control write held until empty (R6)
    for (int i = 0; i < 80 && q.size() > 0; i++) step(1, 1, 1, 0, pat(300 + i), 0, 0, 1);
    step(1, 1, 1, 0, pat(400), 0, 0, 0);
    step(1, 1, 0, 0, pat(401), 0, 0, 0);   // R8 control read

    // R9 change mode/depth while non-empty: not applied until drained
    step(1, 0, 1, 1, pat(500), 0, 0, 0);
    cfg_prefetch = 1'b1; cfg_half_depth = 1'b1;
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 0, 1, 16'hBEEF, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0);            // R9 applies on empty idle edge

    // R7 prefetch, depth 32: control read held until full
    for (int i = 0; i < 20; i++) step(1, 1, 0, 0, pat(600 + i), 1, 16'h3000 + 16'(i), 0);
    step(1, 0, 1, 0, pat(650), 0, 0, 0);     // R5 write in prefetch
    // R4/R10 host reads with concurrent device pushes
    for (int i = 0; i < 40; i++) step(1, 0, 0, i[0], 0, (i % 3) == 0, 16'h4000 + 16'(i), 0);
    for (int i = 0; i < 40 && q.size() > 0; i++) step(1, 0, 0, (i % 4) == 0, 0, 0, 0, 0);

    // R9/R7 full depth in prefetch
    cfg_half_depth = 1'b0;
    step(0, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 36; i++) step(1, 1, 0, 0, pat(700 + i), 1, 16'h5000 + 16'(i), 0);
    for (int i = 0; i < 40 && q.size() > 0; i++) step(1, 0, 0, 1, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0);            // R4 read on empty held

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule